// File: doc/BRIEF.md
# I2S to Quasi-Simultaneous Dual DAC Converter

The block takes a standard two-channel I2S stream with 32 bit clocks per channel slot (64 per frame) and re-times it for two identical I2S-input DACs that are each used only through their right-channel input register. DAC A converts the left channel and DAC B converts the right channel. Both DACs share one regenerated bit clock and one word select, so their outputs update on the same edge.

The left slot is delayed by one slot length so that both words leave together during the input's right slot. While the output word select is high, the shared bit clock carries exactly SAMPLE_BITS+1 pulses. The first pulse fills the one-bit I2S offset and the following ones carry the sample MSB first. The clock and both data lines then stay still. A single latch pulse is inserted on the clock line LATCH_DLY bit periods plus half a bit period after the word select falls. The DACs take that pulse as their output-latch edge. All logic runs on one system clock that oversamples the incoming I2S lines. The serial interfaces have no back-pressure: the block follows the input bit clock and never stalls it.

Top module: `i2s_qsim_conv`

## Requirements
- R1: While reset is asserted and after its release, dac_bck, dac_ws, dac_sd_a and dac_sd_b are 0 until the first input word-select transition is seen.
- R2: dac_ws is high for exactly one input slot (SLOT_BITS bit periods) starting in the input's right slot, and dac_ws changes only while dac_bck is low.
- R3: In every dac_ws-high window, dac_bck has exactly SAMPLE_BITS+1 rising edges (17 by default).
- R4: On dac_sd_b, rising edges 2 to 17 of that window carry bits 31 down to 16 of the current frame's right slot, MSB first.
- R5: On dac_sd_a, rising edges 2 to 17 carry bits 31 down to 16 of the same frame's left slot, which is delayed by SLOT_BITS bit periods.
- R6: The first rising edge of the window carries the preceding slot's last bit: on dac_sd_b that is bit 0 of the current left slot; on dac_sd_a it is bit 0 of the previous frame's right slot (0 for the first frame).
- R7: While dac_ws is low, dac_bck has exactly one rising edge. It comes LATCH_DLY bit periods plus half a bit period after dac_ws falls.
- R8: The latch pulse is high for half a bit period and never overlaps the data burst.
- R9: While dac_ws is low, dac_sd_a and dac_sd_b are 0 and dac_bck toggles exactly twice.
- R10: dac_sd_a and dac_sd_b never change while dac_bck is high, so they are stable at every DAC rising edge.
- R11: No dac_bck edge appears before the first dac_ws rising edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the I2S lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| i2s_bck | input | 1 | Incoming I2S bit clock |
| i2s_ws | input | 1 | Incoming I2S word select, high for the right slot |
| i2s_sd | input | 1 | Incoming I2S serial data |
| dac_bck | output | 1 | Shared gated bit clock carrying the burst and the latch pulse |
| dac_ws | output | 1 | Shared word select to both DACs |
| dac_sd_a | output | 1 | Serial data to DAC A (left channel) |
| dac_sd_b | output | 1 | Serial data to DAC B (right channel) |

## Verification
An error in the slot counter shows in the very next output window, as a burst of the wrong length or a latch edge moved from its expected cycle offset. A fault in the left delay line or in the data selection shows within one frame as a wrong word or a wrong first bit on dac_sd_a. Swept sample patterns (walking ones, extremes and arithmetic sequences) make stuck, swapped or misaligned bits visible at once. A gating fault that leaks clock or data into the quiet interval appears as extra toggles within the same dac_ws-low window.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

  // One oversampled view of the incoming I2S lines
  typedef struct packed {
    logic rise;   // bit clock rising edge seen this cycle
    logic fall;   // bit clock falling edge seen this cycle
    logic ws;     // word select captured with the edge
    logic sd;     // serial data captured with the edge
  } bit_evt_t;

  // Slot timing handed from the counter to the output shapers
  typedef struct packed {
    logic tick_rise;  // registered copy of a rising-edge event
    logic tick_fall;  // registered copy of a falling-edge event
    logic half;       // 1 while in the right slot
    logic armed;      // a word-select transition has been seen
  } slot_ctl_t;

endpackage

// File: rtl/qsc_bit_sampler.sv
module qsc_bit_sampler
  import qsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bck_in,
  input  logic     ws_in,
  input  logic     sd_in,
  output bit_evt_t evt
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] bck_sr, ws_sr, sd_sr;
  logic                   bck_q;

  // All three lines pass through equal stages so they stay aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_sr <= '0;
      ws_sr  <= '0;
      sd_sr  <= '0;
      bck_q  <= 1'b0;
    end else begin
      bck_sr <= {bck_sr[SYNC_STAGES-2:0], bck_in};
      ws_sr  <= {ws_sr[SYNC_STAGES-2:0], ws_in};
      sd_sr  <= {sd_sr[SYNC_STAGES-2:0], sd_in};
      bck_q  <= bck_sr[LAST];
    end
  end

  always_comb begin
    evt.rise = bck_sr[LAST] & ~bck_q;
    evt.fall = ~bck_sr[LAST] & bck_q;
    evt.ws   = ws_sr[LAST];
    evt.sd   = sd_sr[LAST];
  end

endmodule

// File: rtl/qsc_slot_counter.sv
module qsc_slot_counter
  import qsc_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  localparam int CW = $clog2(SLOT_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bit_evt_t      evt,
  output slot_ctl_t     ctl,
  output logic [CW-1:0] cnt,
  output logic          cur_sd
);

  localparam logic [CW-1:0] CNT_MAX = CW'(SLOT_BITS - 1);

  // Position of the current bit inside its slot; restarts on every
  // word-select change and saturates if a slot runs long.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl    <= '0;
      cnt    <= '0;
      cur_sd <= 1'b0;
    end else begin
      ctl.tick_rise <= evt.rise;
      ctl.tick_fall <= evt.fall;
      if (evt.rise) begin
        ctl.half <= evt.ws;
        cur_sd   <= evt.sd;
        if (evt.ws != ctl.half) begin
          cnt       <= '0;
          ctl.armed <= 1'b1;
        end else if (cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/qsc_left_delay.sv
module qsc_left_delay #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] line_q;

  // dout takes the bit that entered DEPTH shift events earlier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      dout   <= 1'b0;
    end else if (shift_en) begin
      dout   <= line_q[DEPTH-1];
      line_q <= {line_q[DEPTH-2:0], din};
    end
  end

endmodule

// File: rtl/qsc_burst_gen.sv
module qsc_burst_gen
  import qsc_pkg::*;
#(
  parameter int SAMPLE_BITS = 16,
  parameter int CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_ctl_t     ctl,
  input  logic [CW-1:0] cnt,
  input  logic          left_bit,
  input  logic          right_bit,
  output logic          burst_clk,
  output logic          ws_out,
  output logic          sd_a,
  output logic          sd_b
);

  localparam logic [CW-1:0] PULSES = CW'(SAMPLE_BITS + 1);

  logic in_win;
  assign in_win = ctl.armed & ctl.half & (cnt < PULSES);

  // Data and word select move while the output clock goes low;
  // the clock rises half a bit later inside the window only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_clk <= 1'b0;
      ws_out    <= 1'b0;
      sd_a      <= 1'b0;
      sd_b      <= 1'b0;
    end else if (ctl.tick_rise) begin
      burst_clk <= 1'b0;
      ws_out    <= ctl.armed & ctl.half;
      sd_a      <= in_win & left_bit;
      sd_b      <= in_win & right_bit;
    end else if (ctl.tick_fall && in_win) begin
      burst_clk <= 1'b1;
    end
  end

endmodule

// File: rtl/qsc_latch_gen.sv
module qsc_latch_gen
  import qsc_pkg::*;
#(
  parameter int LATCH_DLY = 16,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_ctl_t     ctl,
  input  logic [CW-1:0] cnt,
  output logic          latch_clk
);

  localparam logic [CW-1:0] FIRE_POS = CW'(LATCH_DLY);

  logic fire;
  assign fire = ctl.armed & ~ctl.half & (cnt == FIRE_POS);

  // One half-bit pulse in the left slot, far from any data activity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_clk <= 1'b0;
    end else if (ctl.tick_rise) begin
      latch_clk <= 1'b0;
    end else if (ctl.tick_fall && fire) begin
      latch_clk <= 1'b1;
    end
  end

endmodule

// File: rtl/i2s_qsim_conv.sv
module i2s_qsim_conv
  import qsc_pkg::*;
#(
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 16,
  parameter int LATCH_DLY   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bck,
  output logic dac_ws,
  output logic dac_sd_a,
  output logic dac_sd_b
);

  localparam int CW = $clog2(SLOT_BITS);

  bit_evt_t      evt;
  slot_ctl_t     ctl;
  logic [CW-1:0] cnt;
  logic          cur_sd;
  logic          left_bit;
  logic          burst_clk;
  logic          latch_clk;

  qsc_bit_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .bck_in (i2s_bck),
    .ws_in  (i2s_ws),
    .sd_in  (i2s_sd),
    .evt    (evt)
  );

  qsc_slot_counter #(.SLOT_BITS(SLOT_BITS)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .ctl    (ctl),
    .cnt    (cnt),
    .cur_sd (cur_sd)
  );

  qsc_left_delay #(.DEPTH(SLOT_BITS)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (evt.rise),
    .din      (evt.sd),
    .dout     (left_bit)
  );

  qsc_burst_gen #(.SAMPLE_BITS(SAMPLE_BITS), .CW(CW)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .cnt       (cnt),
    .left_bit  (left_bit),
    .right_bit (cur_sd),
    .burst_clk (burst_clk),
    .ws_out    (dac_ws),
    .sd_a      (dac_sd_a),
    .sd_b      (dac_sd_b)
  );

  qsc_latch_gen #(.LATCH_DLY(LATCH_DLY), .CW(CW)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .cnt       (cnt),
    .latch_clk (latch_clk)
  );

  // The two pulse streams never overlap, so OR merges them cleanly
  assign dac_bck = burst_clk | latch_clk;

endmodule

// File: rtl/qsc_checker.sv
module qsc_checker #(
  parameter int PULSES = 17
) (
  input logic clk,
  input logic rst_n,
  input logic dac_bck,
  input logic dac_ws,
  input logic dac_sd_a,
  input logic dac_sd_b,
  input logic burst_clk,
  input logic latch_clk
);

  logic       bck_q, ws_q, seen_fall;
  logic [7:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q     <= 1'b0;
      ws_q      <= 1'b0;
      seen_fall <= 1'b0;
      hi_cnt    <= '0;
      lo_cnt    <= '0;
    end else begin
      bck_q <= dac_bck;
      ws_q  <= dac_ws;
      if (dac_ws && !ws_q)
        hi_cnt <= '0;
      else if (dac_ws && dac_bck && !bck_q && hi_cnt != 8'hFF)
        hi_cnt <= hi_cnt + 1'b1;
      if (!dac_ws && ws_q) begin
        lo_cnt    <= '0;
        seen_fall <= 1'b1;
      end else if (!dac_ws && dac_bck && !bck_q && lo_cnt != 8'hFF) begin
        lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  assert_ws_moves_low_clk_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_ws) |-> !dac_bck);

  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= 8'(PULSES));

  assert_burst_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ws) |-> hi_cnt == 8'(PULSES));

  assert_single_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= 8'd1);

  assert_latch_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_fall && $rose(dac_ws)) |-> lo_cnt == 8'd1);

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_clk && latch_clk));

  assert_quiet_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_ws |-> (!dac_sd_a && !dac_sd_b));

  assert_data_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_bck && $past(dac_bck)) |-> ($stable(dac_sd_a) && $stable(dac_sd_b)));

endmodule

bind i2s_qsim_conv qsc_checker #(.PULSES(SAMPLE_BITS + 1)) u_qsc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .dac_bck   (dac_bck),
  .dac_ws    (dac_ws),
  .dac_sd_a  (dac_sd_a),
  .dac_sd_b  (dac_sd_b),
  .burst_clk (burst_clk),
  .latch_clk (latch_clk)
);

// File: tb/test_i2s_qsim_conv.sv
module test_i2s_qsim_conv;

  localparam int NF        = 40;   // real frames
  localparam int HB        = 4;    // clk cycles per bit-clock half period
  localparam int BITC      = 2 * HB;
  localparam int LATCH_DLY = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i2s_bck = 1'b0, i2s_ws = 1'b0, i2s_sd = 1'b0;
  logic dac_bck, dac_ws, dac_sd_a, dac_sd_b;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic carry = 1'b0;

  always #4 clk = ~clk;

  i2s_qsim_conv i_i2s_qsim_conv (
    .clk(clk), .rst_n(rst_n),
    .i2s_bck(i2s_bck), .i2s_ws(i2s_ws), .i2s_sd(i2s_sd),
    .dac_bck(dac_bck), .dac_ws(dac_ws), .dac_sd_a(dac_sd_a), .dac_sd_b(dac_sd_b)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Sample values: walking ones, extremes, then arithmetic sequences
  function automatic logic [15:0] smp_l(int n);
    if (n >= NF) return 16'h0;
    if (n < 16) return 16'(1) << n;
    case (n)
      16: return 16'h0000;
      17: return 16'hFFFF;
      18: return 16'h8000;
      19: return 16'h7FFF;
      default: return 16'(n * 40503 + 12345);
    endcase
  endfunction

  function automatic logic [15:0] smp_r(int n);
    if (n >= NF) return 16'h0;
    if (n < 16) return ~(16'h8000 >> n);
    case (n)
      16: return 16'hFFFF;
      17: return 16'h0000;
      18: return 16'h7FFF;
      19: return 16'h8000;
      default: return 16'(n * 25173 + 13849);
    endcase
  endfunction

  function automatic logic [31:0] lslot(int n);
    if (n >= NF) return 32'h0;
    return {smp_l(n), 16'(n * 3851 + 7)};
  endfunction

  function automatic logic [31:0] rslot(int n);
    if (n >= NF) return 32'h0;
    return {smp_r(n), 16'(n * 911 + 40000)};
  endfunction

  task automatic send_bit(input logic w, input logic d);
    @(negedge clk);
    i2s_bck = 1'b0; i2s_ws = w; i2s_sd = d;
    repeat (HB - 1) @(negedge clk);
    @(negedge clk);
    i2s_bck = 1'b1;
    repeat (HB - 1) @(negedge clk);
  endtask

  task automatic send_frame(input int n);
    logic [31:0] l, r;
    l = lslot(n);
    r = rslot(n);
    for (int j = 0; j < 32; j++) send_bit(1'b0, (j == 0) ? carry : l[32 - j]);
    carry = l[0];
    for (int j = 0; j < 32; j++) send_bit(1'b1, (j == 0) ? carry : r[32 - j]);
    carry = r[0];
  endtask

  // ---------------- monitor acting as the two DACs ----------------
  int   cyc = 0, fidx = 0, hcnt = 0, lcnt = 0, ltog = 0, idle_tog = 0;
  int   ws_rise_t = 0, ws_fall_t = 0, lrise_t = 0, lwidth = 0;
  bit   seen = 1'b0, seen_fall = 1'b0, low_bad = 1'b0, dchg_bad = 1'b0, mon_on = 1'b0;
  logic pb = 1'b0, pw = 1'b0, pa = 1'b0, pbd = 1'b0;
  logic [16:0] cap_a = '0, cap_b = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (!seen && dac_bck != pb) idle_tog++;
      if (dac_bck && pb && (dac_sd_a != pa || dac_sd_b != pbd)) dchg_bad = 1'b1;
      if (dac_ws && !pw) begin
        if (!seen) chk(idle_tog == 0, "R11 idle bck toggles", idle_tog, 0);
        if (seen_fall) begin
          chk(lcnt == 1, "R7 latch edges", lcnt, 1);
          chk(lrise_t - ws_fall_t == LATCH_DLY * BITC + HB, "R7 latch delay",
              lrise_t - ws_fall_t, LATCH_DLY * BITC + HB);
          chk(lwidth == HB, "R8 latch width", lwidth, HB);
          chk(ltog == 2 && !low_bad, "R9 quiet interval", ltog, 2);
        end
        ws_rise_t = cyc; hcnt = 0; cap_a = '0; cap_b = '0; seen = 1'b1;
      end
      if (dac_ws && dac_bck && !pb) begin
        hcnt++;
        cap_a = {cap_a[15:0], dac_sd_a};
        cap_b = {cap_b[15:0], dac_sd_b};
      end
      if (!dac_ws && pw) begin
        logic [31:0] ls, rs;
        logic        a0;
        ls = lslot(fidx);
        rs = rslot(fidx);
        a0 = (fidx == 0) ? 1'b0 : rslot(fidx - 1)[0];
        chk(cyc - ws_rise_t == 32 * BITC, "R2 ws width", cyc - ws_rise_t, 32 * BITC);
        chk(hcnt == 17, "R3 burst edges", hcnt, 17);
        chk(cap_b[15:0] == rs[31:16], "R4 right word", int'(cap_b[15:0]), int'(rs[31:16]));
        chk(cap_a[15:0] == ls[31:16], "R5 left word", int'(cap_a[15:0]), int'(ls[31:16]));
        chk(cap_b[16] == ls[0], "R6 first bit B", int'(cap_b[16]), int'(ls[0]));
        chk(cap_a[16] == a0, "R6 first bit A", int'(cap_a[16]), int'(a0));
        fidx++;
        ws_fall_t = cyc; lcnt = 0; ltog = 0; low_bad = 1'b0; seen_fall = 1'b1;
      end
      if (!dac_ws) begin
        if (dac_bck != pb) ltog++;
        if (dac_bck && !pb) begin lcnt++; lrise_t = cyc; end
        if (!dac_bck && pb) lwidth = cyc - lrise_t;
        if (dac_sd_a || dac_sd_b) low_bad = 1'b1;
      end
    end
    pb = dac_bck; pw = dac_ws; pa = dac_sd_a; pbd = dac_sd_b;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({dac_bck, dac_ws, dac_sd_a, dac_sd_b} == 4'b0, "R1 in reset",
        int'({dac_bck, dac_ws, dac_sd_a, dac_sd_b}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({dac_bck, dac_ws, dac_sd_a, dac_sd_b} == 4'b0, "R1 after release",
        int'({dac_bck, dac_ws, dac_sd_a, dac_sd_b}), 0);
    mon_on = 1'b1;
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b0);
    chk(idle_tog == 0 && !dac_ws, "R11 before first frame", idle_tog, 0);
    for (int n = 0; n <= NF; n++) send_frame(n);
    for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b0);
    repeat (20) @(negedge clk);
    chk(fidx == NF + 1, "R3 windows seen", fidx, NF + 1);
    chk(!dchg_bad, "R10 data stable while clock high", int'(dchg_bad), 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

endmodule